// File: doc/BRIEF.md
# Oscillator Enable and Ready Control Register

This block is one 32-bit control and status word for two clock sources. One is an internal RC oscillator. The other is an external source, which is either a crystal or an external clock fed straight in. Software writes the word to turn each source on or off, to choose bypass for the external source and to set a 5-bit trim value. The block adds that trim value to a factory calibration byte and drives the 9-bit result to the internal oscillator. It also keeps a read-only ready flag for each source.

Software writes always pass through hardware rules before they take effect:

- A source that currently clocks the system, directly or through the PLL, cannot be switched off by software.
- The bypass choice is frozen while the external source is on.
- Low-power entry turns the external source off.
- Low-power exit turns the internal source on.
- A failure of the external source turns the internal source on when the external source was feeding the system clock.

A ready flag falls a fixed number of that oscillator's clock periods after its enable drops. The block counts this delay in its own clock, scaled by a parameter.

Top module: `osc_ctl_reg`

## Requirements
- R1: After reset, the word reads as follows: internal enable 1, external enable 0, bypass 0, both ready flags 0, trim 16.
- R2: The readback places its fields at these bits, and all other bits read 0:
  - internal enable at bit 0
  - internal ready at bit 1
  - trim at bits 7:3
  - calibration at bits 15:8
  - external enable at bit 16
  - external ready at bit 17
  - bypass at bit 18
- R3: The calibration byte is captured from `cal_in` on the first clock edge after reset is released, and it never changes afterwards. `trim_code` is the 9-bit sum of the calibration byte and the trim field. Trim takes the value of bits 7:3 on every write.
- R4: A write changes bypass (bit 18) only while the external enable is 0. While the external enable is 1, the write leaves bypass unchanged.
- R5: A write of 0 to an enable is ignored while that source clocks the system. The `sysclk_sel` codes are 0 internal, 1 external, 2 PLL and 3 none. With the PLL selected, `pll_src` 0 means internal and 1 means external.
- R6: `lp_enter` clears the external enable on the next edge. This overrides both the R5 guard and a write in the same cycle.
- R7: Either of these sets the internal enable on the next edge, overriding a write of 0 in the same cycle:
  - `lp_exit`;
  - `ext_fail` while the external source clocks the system.

  `ext_fail` has no effect when the external source is not in use.
- R8: Without bypass, a ready flag rises on the edge after the cycle in which its enable is 1 and its stable input is 1. It stays 0 while the stable input is 0.
- R9: With bypass set, the external ready flag ignores `ext_stable`. It rises SYNC_STAGES+1 cycles after the external enable rises (3 by default).
- R10: A ready flag falls exactly OFF_CYCLES×SCALE clock cycles after its enable falls. By default this is 6 cycles for the internal source and 12 for the external source.
- R11: Writes to the ready bits, the calibration bits, bit 2 and bits above 18 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 32 | Write word |
| cal_in | input | 8 | Factory calibration byte, captured after reset |
| int_stable | input | 1 | Internal oscillator reports a stable output |
| ext_stable | input | 1 | External oscillator reports a stable output |
| lp_enter | input | 1 | Pulse: device enters low-power mode |
| lp_exit | input | 1 | Pulse: device leaves low-power mode |
| ext_fail | input | 1 | Pulse: external source failure detected |
| sysclk_sel | input | 2 | Current system clock source code |
| pll_src | input | 1 | PLL reference: 0 internal, 1 external |
| int_en | output | 1 | Internal oscillator enable |
| ext_en | output | 1 | External oscillator enable |
| ext_bypass | output | 1 | External source bypass control |
| trim_code | output | 9 | Calibration plus trim |
| rd_data | output | 32 | Readback word |

## Verification
The properties assume the following about the inputs:

- `sysclk_sel`, `pll_src` and the event pulses are synchronous to `clk`.
- The stable inputs are already synchronized.
- Low-power and failure events are single-cycle pulses.

The stimulus drives every input on the falling edge, and holds each event high for exactly one cycle. It changes the clock-source selection only between writes, never in the cycle of a write. The stimulus sometimes selects a source whose enable is 0, in order to show that the guard depends on the selection alone.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned TRIM_W = 5;
   localparam int unsigned CAL_W  = 8;
   localparam int unsigned CODE_W = CAL_W + 1;

   // field positions of the readback/write word
   localparam int unsigned B_INT_EN  = 0;
   localparam int unsigned B_INT_RDY = 1;
   localparam int unsigned B_TRIM_LO = 3;
   localparam int unsigned B_CAL_LO  = 8;
   localparam int unsigned B_EXT_EN  = 16;
   localparam int unsigned B_EXT_RDY = 17;
   localparam int unsigned B_BYP     = 18;

   localparam int unsigned N_OSC   = 2;
   localparam int unsigned IDX_INT = 0;
   localparam int unsigned IDX_EXT = 1;

   typedef enum logic [1:0] {
      SRC_INT  = 2'd0,
      SRC_EXT  = 2'd1,
      SRC_PLL  = 2'd2,
      SRC_NONE = 2'd3
   } sysclk_src_e;
endpackage

// File: rtl/osc_en_guard.sv
// Next-state rule for one oscillator enable: a guarded software write,
// then hardware clear, then hardware set (highest priority).
module osc_en_guard (
   input  logic cur_en,
   input  logic wr_req,
   input  logic wr_bit,
   input  logic in_use,
   input  logic hw_set,
   input  logic hw_clr,
   output logic nxt_en
);
   always_comb begin
      nxt_en = cur_en;
      if (wr_req && (wr_bit || !in_use)) nxt_en = wr_bit;
      if (hw_clr) nxt_en = 1'b0;
      if (hw_set) nxt_en = 1'b1;
   end
endmodule

// File: rtl/osc_ready_track.sv
// Ready flag of one oscillator: rise on stability (or on a synchronized
// enable in bypass mode), fall a fixed count of clk cycles after disable.
module osc_ready_track #(
   parameter int unsigned DLY         = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_BYPASS  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic stable,
   input  logic bypass,
   output logic rdy
);
   localparam int unsigned CNT_W = $clog2(DLY + 1);

   generate
      if (DLY < 1) begin : g_bad_dly
         $error("osc_ready_track: DLY must be at least 1");
      end
      if (HAS_BYPASS && SYNC_STAGES < 1) begin : g_bad_sync
         $error("osc_ready_track: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic             set_cond;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (HAS_BYPASS) begin : g_byp
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= (sync_q << 1) | SYNC_STAGES'(en);
         end
         assign set_cond = bypass ? sync_q[SYNC_STAGES-1] : stable;
      end else begin : g_plain
         assign set_cond = stable & ~bypass;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy   <= 1'b0;
         cnt_q <= '0;
      end else if (en) begin
         cnt_q <= '0;
         if (set_cond) rdy <= 1'b1;
      end else if (rdy) begin
         if (cnt_q == CNT_W'(DLY - 1)) begin
            rdy   <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/osc_ctl_reg.sv
module osc_ctl_reg
   import osc_ctl_pkg::*;
#(
   parameter int unsigned OFF_CYCLES  = 6,
   parameter int unsigned INT_SCALE   = 1,
   parameter int unsigned EXT_SCALE   = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TRIM_RST    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [CAL_W-1:0]  cal_in,
   input  logic              int_stable,
   input  logic              ext_stable,
   input  logic              lp_enter,
   input  logic              lp_exit,
   input  logic              ext_fail,
   input  logic [1:0]        sysclk_sel,
   input  logic              pll_src,
   output logic              int_en,
   output logic              ext_en,
   output logic              ext_bypass,
   output logic [CODE_W-1:0] trim_code,
   output logic [WORD_W-1:0] rd_data
);
   generate
      if (OFF_CYCLES < 1 || INT_SCALE < 1 || EXT_SCALE < 1) begin : g_bad_dly
         $error("osc_ctl_reg: turn-off delay parameters must be at least 1");
      end
      if (TRIM_RST >= (1 << TRIM_W)) begin : g_bad_trim
         $error("osc_ctl_reg: TRIM_RST does not fit the trim field");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("osc_ctl_reg: SYNC_STAGES must be at least 1");
      end
   endgenerate

   sysclk_src_e      src;
   logic [N_OSC-1:0] in_use, en_q, en_d, rdy, stable, hw_set, hw_clr, wr_bit;
   logic             byp_q, cal_done;
   logic [TRIM_W-1:0] trim_q;
   logic [CAL_W-1:0]  cal_q;

   assign src = sysclk_src_e'(sysclk_sel);

   always_comb begin
      in_use[IDX_INT] = (src == SRC_INT) || ((src == SRC_PLL) && !pll_src);
      in_use[IDX_EXT] = (src == SRC_EXT) || ((src == SRC_PLL) &&  pll_src);
   end

   assign stable = {ext_stable, int_stable};
   assign wr_bit = {wr_data[B_EXT_EN], wr_data[B_INT_EN]};
   assign hw_set = {1'b0, lp_exit | (ext_fail & in_use[IDX_EXT])};
   assign hw_clr = {lp_enter, 1'b0};

   generate
      for (genvar i = 0; i < N_OSC; i++) begin : g_osc
         localparam bit          IS_EXT = (i == IDX_EXT);
         localparam int unsigned SCALE  = IS_EXT ? EXT_SCALE : INT_SCALE;

         osc_en_guard u_guard (
            .cur_en (en_q[i]),
            .wr_req (wr_en),
            .wr_bit (wr_bit[i]),
            .in_use (in_use[i]),
            .hw_set (hw_set[i]),
            .hw_clr (hw_clr[i]),
            .nxt_en (en_d[i])
         );

         osc_ready_track #(
            .DLY         (OFF_CYCLES * SCALE),
            .SYNC_STAGES (SYNC_STAGES),
            .HAS_BYPASS  (IS_EXT)
         ) u_rdy (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_q[i]),
            .stable (stable[i]),
            .bypass (IS_EXT ? byp_q : 1'b0),
            .rdy    (rdy[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= N_OSC'(1) << IDX_INT;
         byp_q  <= 1'b0;
         trim_q <= TRIM_W'(TRIM_RST);
      end else begin
         en_q <= en_d;
         if (wr_en && !en_q[IDX_EXT]) byp_q <= wr_data[B_BYP];
         if (wr_en) trim_q <= wr_data[B_TRIM_LO +: TRIM_W];
      end
   end

   // calibration is sampled once, on the first edge after reset release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_q    <= '0;
         cal_done <= 1'b0;
      end else if (!cal_done) begin
         cal_q    <= cal_in;
         cal_done <= 1'b1;
      end
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data[WORD_W-1:B_BYP+1], wr_data[B_EXT_RDY],
                             wr_data[B_EXT_EN-1:B_CAL_LO], wr_data[B_TRIM_LO-1:B_INT_RDY]};

   always_comb begin
      rd_data                          = '0;
      rd_data[B_INT_EN]                = en_q[IDX_INT];
      rd_data[B_INT_RDY]               = rdy[IDX_INT];
      rd_data[B_TRIM_LO +: TRIM_W]     = trim_q;
      rd_data[B_CAL_LO +: CAL_W]       = cal_q;
      rd_data[B_EXT_EN]                = en_q[IDX_EXT];
      rd_data[B_EXT_RDY]               = rdy[IDX_EXT];
      rd_data[B_BYP]                   = byp_q;
   end

   assign int_en     = en_q[IDX_INT];
   assign ext_en     = en_q[IDX_EXT];
   assign ext_bypass = byp_q;
   assign trim_code  = CODE_W'(cal_q) + CODE_W'(trim_q);
endmodule

// File: rtl/osc_ctl_reg_chk.sv
module osc_ctl_reg_chk
   import osc_ctl_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              lp_enter,
   input logic              lp_exit,
   input logic              ext_fail,
   input logic [1:0]        sysclk_sel,
   input logic              pll_src,
   input logic              int_en,
   input logic              ext_en,
   input logic              ext_bypass,
   input logic [CODE_W-1:0] trim_code,
   input logic [WORD_W-1:0] rd_data
);
   logic int_used, ext_used, int_rdy, ext_rdy;
   assign int_used = (sysclk_sel == 2'd0) || (sysclk_sel == 2'd2 && !pll_src);
   assign ext_used = (sysclk_sel == 2'd1) || (sysclk_sel == 2'd2 &&  pll_src);
   assign int_rdy  = rd_data[B_INT_RDY];
   assign ext_rdy  = rd_data[B_EXT_RDY];

   p_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trim_code == CODE_W'(rd_data[B_CAL_LO +: CAL_W]) + CODE_W'(rd_data[B_TRIM_LO +: TRIM_W]));

   p_byp_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ext_en |=> $stable(ext_bypass));

   p_int_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en && int_used) |=> int_en);

   p_ext_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_en && ext_used && !lp_enter) |=> ext_en);

   p_lp_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lp_enter |=> !ext_en);

   p_int_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_exit || (ext_fail && ext_used)) |=> int_en);

   p_int_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_rdy) |-> $past(int_en));

   p_int_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_rdy) |-> !$past(int_en));

   p_ext_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_rdy) |-> !$past(ext_en));

   logic unused_rd;
   assign unused_rd = ^{rd_data[WORD_W-1:B_EXT_RDY+1], rd_data[B_EXT_EN-1:B_CAL_LO+CAL_W],
                        rd_data[B_TRIM_LO-1:B_INT_RDY+1], rd_data[B_INT_EN]};
endmodule

bind osc_ctl_reg osc_ctl_reg_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lp_enter   (lp_enter),
   .lp_exit    (lp_exit),
   .ext_fail   (ext_fail),
   .sysclk_sel (sysclk_sel),
   .pll_src    (pll_src),
   .int_en     (int_en),
   .ext_en     (ext_en),
   .ext_bypass (ext_bypass),
   .trim_code  (trim_code),
   .rd_data    (rd_data)
);

// File: tb/test_osc_ctl_reg.sv
module test_osc_ctl_reg;
   localparam int CLK_PERIOD = 10;
   localparam int INT_DLY = 6;
   localparam int EXT_DLY = 12;
   localparam int SYNC    = 2;

   localparam int SEL_RD = 0, SEL_IEN = 1, SEL_EEN = 2, SEL_BYP = 3,
                  SEL_TRIM = 4, SEL_IRDY = 5, SEL_ERDY = 6;

   localparam logic [31:0] T   = 32'h0000_00F8; // trim = 31
   localparam logic [31:0] IE  = 32'h0000_0001;
   localparam logic [31:0] EE  = 32'h0001_0000;
   localparam logic [31:0] BYP = 32'h0004_0000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 1'b0, int_stable = 1'b0, ext_stable = 1'b0;
   logic        lp_enter = 1'b0, lp_exit = 1'b0, ext_fail = 1'b0, pll_src = 1'b0;
   logic [31:0] wr_data = '0;
   logic [7:0]  cal_in = 8'h5A;
   logic [1:0]  sysclk_sel = 2'd0;
   logic        int_en, ext_en, ext_bypass;
   logic [8:0]  trim_code;
   logic [31:0] rd_data;

   osc_ctl_reg #(.OFF_CYCLES(6), .INT_SCALE(1), .EXT_SCALE(2), .SYNC_STAGES(SYNC),
                 .TRIM_RST(16)) i_osc_ctl_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cal_in(cal_in),
      .int_stable(int_stable), .ext_stable(ext_stable), .lp_enter(lp_enter),
      .lp_exit(lp_exit), .ext_fail(ext_fail), .sysclk_sel(sysclk_sel), .pll_src(pll_src),
      .int_en(int_en), .ext_en(ext_en), .ext_bypass(ext_bypass),
      .trim_code(trim_code), .rd_data(rd_data));

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          at;
      int          sel;
      logic [31:0] val;
      string       req;
   } item_t;

   item_t sb[$];
   int    cyc = 0, checks = 0, errors = 0;
   bit    done = 1'b0;

   function automatic logic [31:0] probe(int sel);
      case (sel)
         SEL_RD:   return rd_data;
         SEL_IEN:  return {31'b0, int_en};
         SEL_EEN:  return {31'b0, ext_en};
         SEL_BYP:  return {31'b0, ext_bypass};
         SEL_TRIM: return {23'b0, trim_code};
         SEL_IRDY: return {31'b0, rd_data[1]};
         SEL_ERDY: return {31'b0, rd_data[17]};
         default:  return '0;
      endcase
   endfunction

   task automatic expect_at(int d, int sel, logic [31:0] v, string req);
      sb.push_back('{cyc + d, sel, v, req});
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(bit w, logic [31:0] d, bit lpi, bit lpo, bit f);
      wr_en = w; wr_data = d; lp_enter = lpi; lp_exit = lpo; ext_fail = f;
      @(negedge clk);
      wr_en = 1'b0; lp_enter = 1'b0; lp_exit = 1'b0; ext_fail = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // monitor: compares scoreboard items due in this cycle
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
               logic [31:0] act;
               act = probe(sb[i].sel);
               checks++;
               if (act !== sb[i].val) begin
                  errors++;
                  $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h",
                           sb[i].req, sb[i].sel, cyc, act, sb[i].val);
               end
               sb.delete(i);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      // R1 reset word: int_en, trim 16, cal 0x5A
      expect_at(1, SEL_RD, 32'h0000_5A81, "R1");
      expect_at(1, SEL_TRIM, 32'h6A, "R3");
      step(1);
      cal_in = 8'h33;

      // R11 read-only bits written with ones, trim 5
      expect_at(1, SEL_RD, 32'h0000_5A29, "R11");
      expect_at(1, SEL_TRIM, 32'h5F, "R3");
      pulse(1, 32'hFFF8_FF2F & ~BYP & ~EE, 0, 0, 0);

      // R3 trim maximum
      expect_at(1, SEL_TRIM, 32'h79, "R3");
      pulse(1, T | IE, 0, 0, 0);

      // R8 internal ready rises
      int_stable = 1'b1;
      expect_at(1, SEL_IRDY, 1, "R8");
      step(1);

      // R5 guard: direct and through PLL
      sysclk_sel = 2'd0;
      expect_at(1, SEL_IEN, 1, "R5");
      pulse(1, T, 0, 0, 0);
      sysclk_sel = 2'd2; pll_src = 1'b0;
      expect_at(1, SEL_IEN, 1, "R5");
      pulse(1, T, 0, 0, 0);
      pll_src = 1'b1;
      expect_at(1, SEL_IEN, 0, "R5");
      expect_at(INT_DLY, SEL_IRDY, 1, "R10");
      expect_at(INT_DLY + 1, SEL_IRDY, 0, "R10");
      pulse(1, T, 0, 0, 0);
      step(INT_DLY + 1);

      // R8 external ready waits for stable
      sysclk_sel = 2'd3;
      expect_at(1, SEL_EEN, 1, "R8");
      expect_at(4, SEL_ERDY, 0, "R8");
      pulse(1, T | IE | EE, 0, 0, 0);
      step(4);
      ext_stable = 1'b1;
      expect_at(1, SEL_ERDY, 1, "R8");
      step(1);

      // R4 bypass locked while external enabled
      expect_at(1, SEL_BYP, 0, "R4");
      pulse(1, T | IE | EE | BYP, 0, 0, 0);

      // R5 external clear blocked while in use
      sysclk_sel = 2'd1;
      expect_at(1, SEL_EEN, 1, "R5");
      pulse(1, T | IE, 0, 0, 0);

      // R6 low-power entry beats a set write; R10 external fall at 12
      expect_at(1, SEL_EEN, 0, "R6");
      expect_at(EXT_DLY, SEL_ERDY, 1, "R10");
      expect_at(EXT_DLY + 1, SEL_ERDY, 0, "R10");
      pulse(1, T | IE | EE, 1, 0, 0);
      step(EXT_DLY + 1);

      // R7 low-power exit beats a clear write
      expect_at(1, SEL_IEN, 0, "R7");
      pulse(1, T, 0, 0, 0);
      expect_at(1, SEL_IEN, 1, "R7");
      pulse(1, T, 0, 1, 0);

      // R7 failure ignored when external not in use
      sysclk_sel = 2'd3;
      expect_at(1, SEL_IEN, 0, "R7");
      pulse(1, T, 0, 0, 0);
      expect_at(1, SEL_IEN, 0, "R7");
      pulse(0, '0, 0, 0, 1);

      // R7 failure with external feeding the PLL
      sysclk_sel = 2'd2; pll_src = 1'b1;
      expect_at(1, SEL_IEN, 1, "R7");
      pulse(0, '0, 0, 0, 1);
      step(2);

      // R9 bypass: ready follows enable, ignores stable
      sysclk_sel = 2'd3; ext_stable = 1'b0;
      expect_at(1, SEL_BYP, 1, "R9");
      pulse(1, T | IE | BYP, 0, 0, 0);
      expect_at(1, SEL_EEN, 1, "R9");
      expect_at(SYNC + 1, SEL_ERDY, 0, "R9");
      expect_at(SYNC + 2, SEL_ERDY, 1, "R9");
      pulse(1, T | IE | EE | BYP, 0, 0, 0);
      step(SYNC + 2);

      // R2 full layout, calibration unchanged by cal_in (R3)
      expect_at(1, SEL_RD, 32'h0007_5AFB, "R2");
      step(1);

      // R10 external fall in bypass mode
      expect_at(1, SEL_EEN, 0, "R10");
      expect_at(EXT_DLY, SEL_ERDY, 1, "R10");
      expect_at(EXT_DLY + 1, SEL_ERDY, 0, "R10");
      pulse(1, T | IE | BYP, 0, 0, 0);
      step(EXT_DLY + 2);

      if (sb.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard left %0d items actual=%0d expected=0", sb.size(), sb.size());
      end
      done = 1'b1;
      finish_run();
   end
endmodule